// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

The walker steps through a ring of transmit descriptors that host software has filled in, and turns them into an ordered stream of buffer requests for a downstream DMA engine. For each ring slot it fetches a 32-bit status word and a buffer byte count over a valid/ready read port. It passes over slots until it meets one that the controller owns and that opens a frame. From there it follows the chain to the slot that closes the frame. It issues one request per buffer, each carrying the slot index, the byte count and the frame position flags.

On the closing request the walker also gives the frame's FCS decision. That decision combines the closing descriptor's append-FCS bit, a global FCS disable and an auto-pad rule for frames shorter than 64 bytes. If a slot that is not owned stops the scan, the walker parks until a poll pulse arrives. A frame that is already open stays open while the walker waits. If a new frame start turns up in the middle of a chain, the open frame is closed with an error marker.

Top module: `tdw_walker`

## Requirements
- R1: After reset the walker is idle: `desc_ready_o`=0, `buf_valid_o`=0 and `desc_idx_o`=0.
- R2: A `poll_i` pulse while idle starts a fetch of the slot at `desc_idx_o`. A descriptor is consumed in a cycle where `desc_valid_i` and `desc_ready_o` are both 1. The walker never fetches and requests in the same cycle.
- R3: A fetched word with bit 31 (owned) at 0 stops the walker. It stays idle at that index and fetches nothing more until `poll_i`.
- R4: Outside a frame, an owned word with bit 25 (frame start) at 0 is skipped. No request is made for it and the next slot is fetched.
- R5: An owned word with both bit 25 and bit 24 (frame end) set gives one request with first=1 and last=1.
- R6: A chain gives one request per slot, each with its slot index and byte count. The start slot has first=1, last=0. Middle slots have 0/0. The slot with bit 24 has first=0, last=1.
- R7: The slot index wraps from RING_LEN-1 to 0, and chains may span the wrap.
- R8: Inside a chain, an owned word with bit 25 set produces an error request for that slot: length 0, first=0, last=1, err=1, fcs=0. That slot is then fetched again and handled as a new frame start.
- R9: On a closing request, fcs = (bit 29 of the closing word) OR NOT `fcs_dis_i`. Bit 29 on slots that do not close the frame has no effect.
- R10: With `apad_en_i`=1 and a frame total below 64 bytes, bit 29 is ignored and fcs = NOT `fcs_dis_i`. A total of exactly 64 is not short.
- R11: While `buf_valid_o`=1 and `buf_ready_i`=0, the request and all its fields stay unchanged.
- R12: The fcs and err flags are 0 on every request that does not close a frame.
- R13: If a slot inside a chain is not owned, the walker idles and keeps the chain open. After `poll_i` it fetches that slot again and continues the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_i | input | 1 | Restart scanning when idle |
| fcs_dis_i | input | 1 | Global FCS disable |
| apad_en_i | input | 1 | Auto-pad enable (short-frame rule) |
| desc_ready_o | output | 1 | Walker wants the descriptor at desc_idx_o |
| desc_idx_o | output | IDX_W | Ring slot being fetched |
| desc_valid_i | input | 1 | Descriptor data valid |
| desc_word_i | input | 32 | Descriptor status word |
| desc_len_i | input | LEN_W | Buffer byte count |
| buf_valid_o | output | 1 | Buffer request valid |
| buf_ready_i | input | 1 | DMA accepts request |
| buf_idx_o | output | IDX_W | Slot of the request |
| buf_len_o | output | LEN_W | Byte count (0 on error marker) |
| buf_first_o | output | 1 | First buffer of frame |
| buf_last_o | output | 1 | Last buffer of frame |
| buf_fcs_o | output | 1 | Append FCS (closing request only) |
| buf_err_o | output | 1 | Frame ended by a stray start |

## Verification
The bench goes after several weak points. Skipped owned slots that are not frame starts would leak out as extra requests in a walker that forgets to skip. A chain across the ring wrap would come out with wrong indices if the index counter wrapped badly. A stray start inside a chain tests whether the walker marks the error and then fetches the slot again; a walker that drops or duplicates that slot fails here. A chain paused on an unowned slot checks that the frame is resumed, not restarted with first=1.

All sixteen combinations of append bit, global disable, auto-pad and a 63/64-byte length are swept. A wrong short-frame limit or wrong precedence shows up as a flipped fcs flag. An append bit set only on a start slot checks that it is not taken from the wrong descriptor. Random stalls on the request port catch fields that change while a request is held.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int DESC_W      = 32;
  localparam int OWN_BIT     = 31;
  localparam int ADD_FCS_BIT = 29;
  localparam int STP_BIT     = 25;
  localparam int ENP_BIT     = 24;
  localparam int MIN_FRAME   = 64;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EMIT = 2'd2
  } tdw_state_e;
endpackage

// File: rtl/tdw_ring_ptr.sv
module tdw_ring_ptr #(
  parameter int RING_LEN = 8,
  localparam int IDX_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_nxt;

  generate
    if ((1 << IDX_W) == RING_LEN) begin : g_pow2
      assign idx_nxt = idx_q + 1'b1;
    end else begin : g_cmp
      assign idx_nxt = (idx_q == IDX_W'(RING_LEN - 1)) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_nxt;
  end

  assign idx_o = idx_q;

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && idx_q == IDX_W'(RING_LEN - 1) |=> idx_q == '0);

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/tdw_len_acc.sv
module tdw_len_acc #(
  parameter int LEN_W  = 12,
  parameter int FLEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cont_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [FLEN_W-1:0] total_o
);
  logic [FLEN_W-1:0] acc_q, base;
  logic [FLEN_W:0]   sum;

  assign base    = cont_i ? acc_q : '0;
  assign sum     = {1'b0, base} + (FLEN_W+1)'(len_i);
  assign total_o = sum[FLEN_W] ? '1 : sum[FLEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= total_o;
  end

  // running total never shrinks inside a frame (R10 length basis)
  a_r10_acc_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && cont_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/tdw_fcs_decide.sv
module tdw_fcs_decide import tdw_pkg::*; #(
  parameter int FLEN_W = 16
) (
  input  logic              add_fcs_i,
  input  logic              fcs_dis_i,
  input  logic              apad_en_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  output logic              fcs_o
);
  logic short_frame;

  assign short_frame = apad_en_i && (frame_len_i < FLEN_W'(MIN_FRAME));
  assign fcs_o       = (add_fcs_i && !short_frame) || !fcs_dis_i;
endmodule

// File: rtl/tdw_scan_fsm.sv
module tdw_scan_fsm import tdw_pkg::*; #(
  parameter int LEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              desc_valid_i,
  input  logic [DESC_W-1:0] desc_word_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic              buf_ready_i,
  input  logic              fcs_dec_i,
  output logic              desc_ready_o,
  output logic              adv_o,
  output logic              acc_load_o,
  output logic              acc_cont_o,
  output logic              add_fcs_o,
  output logic              buf_valid_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              buf_first_o,
  output logic              buf_last_o,
  output logic              buf_fcs_o,
  output logic              buf_err_o
);
  tdw_state_e state_q;
  logic in_chain_q, abort_q;
  logic own, stp, enp;
  logic rd_fire, skip, brk, take, emit_done;
  logic unused_word;

  assign own = desc_word_i[OWN_BIT];
  assign stp = desc_word_i[STP_BIT];
  assign enp = desc_word_i[ENP_BIT];
  assign unused_word = ^{desc_word_i[30], desc_word_i[28:26], desc_word_i[23:0]};

  assign rd_fire   = (state_q == ST_READ) && desc_valid_i;
  assign skip      = rd_fire && own && !in_chain_q && !stp;
  assign brk       = rd_fire && own && in_chain_q && stp;
  assign take      = rd_fire && own && (in_chain_q ? !stp : stp);
  assign emit_done = (state_q == ST_EMIT) && buf_ready_i;

  assign adv_o        = skip || (emit_done && !abort_q);
  assign acc_load_o   = take;
  assign acc_cont_o   = in_chain_q;
  assign add_fcs_o    = desc_word_i[ADD_FCS_BIT];
  assign desc_ready_o = (state_q == ST_READ);
  assign buf_valid_o  = (state_q == ST_EMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      in_chain_q  <= 1'b0;
      abort_q     <= 1'b0;
      buf_len_o   <= '0;
      buf_first_o <= 1'b0;
      buf_last_o  <= 1'b0;
      buf_fcs_o   <= 1'b0;
      buf_err_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (poll_i) state_q <= ST_READ;
        ST_READ: begin
          if (rd_fire && !own) begin
            state_q <= ST_IDLE;
          end else if (brk) begin
            state_q     <= ST_EMIT;
            abort_q     <= 1'b1;
            buf_len_o   <= '0;
            buf_first_o <= 1'b0;
            buf_last_o  <= 1'b1;
            buf_fcs_o   <= 1'b0;
            buf_err_o   <= 1'b1;
          end else if (take) begin
            state_q     <= ST_EMIT;
            abort_q     <= 1'b0;
            buf_len_o   <= desc_len_i;
            buf_first_o <= !in_chain_q;
            buf_last_o  <= enp;
            buf_fcs_o   <= enp && fcs_dec_i;
            buf_err_o   <= 1'b0;
          end
        end
        ST_EMIT: if (buf_ready_i) begin
          state_q    <= ST_READ;
          in_chain_q <= abort_q ? 1'b0 : !buf_last_o;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(desc_ready_o && buf_valid_o));

  a_r3_stop_unowned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o && desc_valid_i && !own |=> !desc_ready_o && !buf_valid_o);

  a_r8_err_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && buf_err_o |-> buf_last_o && !buf_first_o && buf_len_o == '0 && !buf_fcs_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && !buf_ready_i |=> buf_valid_o &&
      $stable({buf_len_o, buf_first_o, buf_last_o, buf_fcs_o, buf_err_o}));

  a_r12_flags_last_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && !buf_last_o |-> !buf_fcs_o && !buf_err_o);

  a_r13_resume_keeps_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o && take && in_chain_q |=> buf_valid_o && !buf_first_o);
endmodule

// File: rtl/tdw_walker.sv
module tdw_walker import tdw_pkg::*; #(
  parameter int RING_LEN = 8,
  parameter int LEN_W    = 12,
  parameter int FLEN_W   = 16,
  localparam int IDX_W   = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              fcs_dis_i,
  input  logic              apad_en_i,
  output logic              desc_ready_o,
  output logic [IDX_W-1:0]  desc_idx_o,
  input  logic              desc_valid_i,
  input  logic [DESC_W-1:0] desc_word_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  output logic              buf_valid_o,
  input  logic              buf_ready_i,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              buf_first_o,
  output logic              buf_last_o,
  output logic              buf_fcs_o,
  output logic              buf_err_o
);
  logic              adv, acc_load, acc_cont, add_fcs, fcs_dec;
  logic [IDX_W-1:0]  idx;
  logic [FLEN_W-1:0] frame_len;

  tdw_ring_ptr #(.RING_LEN(RING_LEN)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .idx_o  (idx)
  );

  tdw_len_acc #(.LEN_W(LEN_W), .FLEN_W(FLEN_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (acc_load),
    .cont_i  (acc_cont),
    .len_i   (desc_len_i),
    .total_o (frame_len)
  );

  tdw_fcs_decide #(.FLEN_W(FLEN_W)) u_fcs (
    .add_fcs_i   (add_fcs),
    .fcs_dis_i   (fcs_dis_i),
    .apad_en_i   (apad_en_i),
    .frame_len_i (frame_len),
    .fcs_o       (fcs_dec)
  );

  tdw_scan_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .poll_i       (poll_i),
    .desc_valid_i (desc_valid_i),
    .desc_word_i  (desc_word_i),
    .desc_len_i   (desc_len_i),
    .buf_ready_i  (buf_ready_i),
    .fcs_dec_i    (fcs_dec),
    .desc_ready_o (desc_ready_o),
    .adv_o        (adv),
    .acc_load_o   (acc_load),
    .acc_cont_o   (acc_cont),
    .add_fcs_o    (add_fcs),
    .buf_valid_o  (buf_valid_o),
    .buf_len_o    (buf_len_o),
    .buf_first_o  (buf_first_o),
    .buf_last_o   (buf_last_o),
    .buf_fcs_o    (buf_fcs_o),
    .buf_err_o    (buf_err_o)
  );

  assign desc_idx_o = idx;
  assign buf_idx_o  = idx;

  a_r11_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && !buf_ready_i |=> $stable(buf_idx_o));
endmodule

// File: tb/tdw_walker_test.sv
`timescale 1ns/1ps
module tdw_walker_test;
  localparam int RING = 8;
  localparam int LW   = 12;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll = 1'b0, fcs_dis = 1'b0, apad = 1'b0;
  logic desc_ready, desc_valid = 1'b0;
  logic [IW-1:0] desc_idx, buf_idx;
  logic [31:0] desc_word = '0;
  logic [LW-1:0] desc_len = '0, buf_len;
  logic buf_valid, buf_ready = 1'b0, buf_first, buf_last, buf_fcs, buf_err;

  always #2 clk = ~clk;

  tdw_walker #(.RING_LEN(RING), .LEN_W(LW), .FLEN_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .poll_i(poll), .fcs_dis_i(fcs_dis), .apad_en_i(apad),
    .desc_ready_o(desc_ready), .desc_idx_o(desc_idx), .desc_valid_i(desc_valid),
    .desc_word_i(desc_word), .desc_len_i(desc_len),
    .buf_valid_o(buf_valid), .buf_ready_i(buf_ready), .buf_idx_o(buf_idx),
    .buf_len_o(buf_len), .buf_first_o(buf_first), .buf_last_o(buf_last),
    .buf_fcs_o(buf_fcs), .buf_err_o(buf_err)
  );

  typedef struct {
    int idx; int len; bit first; bit last; bit fcs; bit err; string tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] mem_w [RING];
  logic [LW-1:0] mem_l [RING];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put_desc(input int i, input bit own, input bit stp, input bit enp,
                          input bit add, input int len);
    mem_w[i] = '0;
    mem_w[i][31] = own; mem_w[i][29] = add; mem_w[i][25] = stp; mem_w[i][24] = enp;
    mem_l[i] = LW'(len);
  endtask

  task automatic push(input int i, input int len, input bit f, input bit l,
                      input bit fc, input bit er, input string tag);
    exp_t e;
    e.idx = i; e.len = len; e.first = f; e.last = l; e.fcs = fc; e.err = er; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic bit exp_fcs(input bit add, input bit dis, input bit ap, input int total);
    return (add && !(ap && total < 64)) || !dis;
  endfunction

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (q.size() == 0 && !desc_ready && !buf_valid) quiet++;
      else quiet = 0;
    end
  endtask

  // descriptor responder
  initial begin
    bit prq = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin desc_valid = 1'b0; prq = 0; end
      else begin
        if (desc_valid && prq) desc_valid = 1'b0;
        else if (desc_ready && !desc_valid) begin
          desc_word = mem_w[desc_idx]; desc_len = mem_l[desc_idx]; desc_valid = 1'b1;
        end
        prq = desc_ready;
      end
    end
  end

  // request monitor / scoreboard
  initial begin
    bit pv = 0, pr = 0;
    int scnt = 0;
    int c_idx = 0, c_len = 0;
    bit c_f = 0, c_l = 0, c_fc = 0, c_er = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin pv = 0; pr = 0; buf_ready = 1'b0; end
      else begin
        if (pv && pr) begin
          if (q.size() == 0) chk(0, "R4", "unexpected request idx", c_idx, -1);
          else begin
            e = q.pop_front();
            chk(c_idx == e.idx, e.tag, "idx", c_idx, e.idx);
            chk(c_len == e.len, e.tag, "len", c_len, e.len);
            chk(c_f == e.first, e.tag, "first", c_f, e.first);
            chk(c_l == e.last, e.tag, "last", c_l, e.last);
            chk(c_fc == e.fcs, e.tag, "fcs", c_fc, e.fcs);
            chk(c_er == e.err, e.tag, "err", c_er, e.err);
          end
          if (!c_er) mem_w[c_idx][31] = 1'b0;
        end else if (pv && !pr) begin
          chk(buf_valid && int'(buf_idx) == c_idx && int'(buf_len) == c_len &&
              buf_first == c_f && buf_last == c_l && buf_fcs == c_fc && buf_err == c_er,
              "R11", "held request changed, idx", int'(buf_idx), c_idx);
        end
        pv = buf_valid;
        c_idx = int'(buf_idx); c_len = int'(buf_len);
        c_f = buf_first; c_l = buf_last; c_fc = buf_fcs; c_er = buf_err;
        scnt++;
        buf_ready = (scnt % 3) != 1;
        pr = buf_ready;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pos;
    for (int i = 0; i < RING; i++) put_desc(i, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!desc_ready, "R1", "desc_ready", desc_ready, 0);
    chk(!buf_valid, "R1", "buf_valid", buf_valid, 0);
    chk(desc_idx == 0, "R1", "desc_idx", int'(desc_idx), 0);

    // R5 single-buffer frame, R9 global enable
    put_desc(0, 1, 1, 1, 0, 100);
    push(0, 100, 1, 1, 1, 0, "R5");
    do_poll(); wait_idle();
    chk(desc_idx == 1, "R3", "stop index", int'(desc_idx), 1);
    chk(!desc_ready, "R3", "fetching after unowned", desc_ready, 0);

    // R4 skip two owned non-start slots, R6 three-buffer chain
    fcs_dis = 1'b1;
    put_desc(1, 1, 0, 0, 0, 5);
    put_desc(2, 1, 0, 0, 0, 6);
    put_desc(3, 1, 1, 0, 0, 40);
    put_desc(4, 1, 0, 0, 0, 40);
    put_desc(5, 1, 0, 1, 1, 40);
    push(3, 40, 1, 0, 0, 0, "R6");
    push(4, 40, 0, 0, 0, 0, "R6");
    push(5, 40, 0, 1, 1, 0, "R9");
    do_poll(); wait_idle();
    chk(desc_idx == 6, "R4", "stop index", int'(desc_idx), 6);
    put_desc(1, 0, 0, 0, 0, 0);
    put_desc(2, 0, 0, 0, 0, 0);

    // R7 chain across the wrap
    fcs_dis = 1'b0; apad = 1'b1;
    put_desc(6, 1, 1, 0, 0, 30);
    put_desc(7, 1, 0, 0, 0, 30);
    put_desc(0, 1, 0, 1, 0, 30);
    push(6, 30, 1, 0, 0, 0, "R7");
    push(7, 30, 0, 0, 0, 0, "R7");
    push(0, 30, 0, 1, 1, 0, "R7");
    do_poll(); wait_idle();
    chk(desc_idx == 1, "R7", "index after wrap", int'(desc_idx), 1);

    // R9 append bit on start slot only has no effect
    fcs_dis = 1'b1; apad = 1'b0;
    put_desc(1, 1, 1, 0, 1, 50);
    put_desc(2, 1, 0, 1, 0, 50);
    push(1, 50, 1, 0, 0, 0, "R12");
    push(2, 50, 0, 1, 0, 0, "R9");
    do_poll(); wait_idle();

    // R8 stray start inside chain
    put_desc(3, 1, 1, 0, 0, 10);
    put_desc(4, 1, 1, 1, 1, 50);
    push(3, 10, 1, 0, 0, 0, "R8");
    push(4, 0, 0, 1, 0, 1, "R8");
    push(4, 50, 1, 1, 1, 0, "R8");
    do_poll(); wait_idle();

    // R13 chain paused on unowned slot, then resumed; short total (R10)
    apad = 1'b1;
    put_desc(5, 1, 1, 0, 0, 20);
    push(5, 20, 1, 0, 0, 0, "R13");
    do_poll(); wait_idle();
    chk(desc_idx == 6, "R13", "paused index", int'(desc_idx), 6);
    put_desc(6, 1, 0, 1, 1, 30);
    push(6, 30, 0, 1, exp_fcs(1, 1, 1, 50), 0, "R13");
    do_poll(); wait_idle();
    pos = 7;

    // R10 / R9 full sweep of FCS inputs with 63/64-byte boundary
    for (int c = 0; c < 16; c++) begin
      bit add, dis, ap;
      int len;
      add = c[0]; dis = c[1]; ap = c[2];
      len = c[3] ? 63 : 64;
      fcs_dis = dis; apad = ap;
      put_desc(pos, 1, 1, 1, add, len);
      push(pos, len, 1, 1, exp_fcs(add, dis, ap, len), 0, "R10");
      do_poll(); wait_idle();
      pos = (pos + 1) % RING;
    end
    chk(int'(desc_idx) == pos, "R2", "final index", int'(desc_idx), pos);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule